// File: doc/BRIEF.md
# Shared External SRAM Access Controller

This block lets three independent clients share one external asynchronous SRAM. Each client sends a short command of 18-bit words over its own valid/ready channel. The block grants one client at a time, in round-robin order. It collects that client's command, runs one of five operations to completion, and returns any reply word on that client's reply channel. Only then does it consider another client.

The five operations are:
- read a word;
- write a word;
- compare-and-exchange, which stores a new value only when the stored word matches an expected value and reports success or failure;
- load a 16-bit master enable mask;
- post stimuli to a set of masters, which gives a one-cycle pulse on each stimulus line that is both selected and enabled.

The operation is chosen by the sign flags of the first two words. No opcode field exists.

The SRAM side has a 20-bit address made of a 4-bit page above a 16-bit offset, a write data bus with a drive enable, a read data bus, and active-low chip, write and output enables. Every access holds its strobes for a fixed, parameterised number of cycles.

Top module: `xms_top`

## Requirements
- R1: While reset is held and on the first cycle after it, all three SRAM strobes are high, no client sees ready or reply valid, and no stimulus line is high. The enable mask resets to zero.
- R2: A command word is 18 bits. Bit 17 is the sign flag (1 = negative) and bits 15:0 are the value; bit 16 is ignored. The two first-word signs select the operation: (+,+) read, (-,-) write, (-,+) compare-and-exchange, (+,-) mask command.
- R3: Read (+page, +offset) replies with the word stored at {page[3:0], offset}. Output enable stays low through the edge that captures the data.
- R4: Write (-page, -offset, data) stores data at {page[3:0], offset} and sends no reply.
- R5: Compare-and-exchange (-n, +page, offset, w) reads the addressed word. When it equals n, the block writes w and replies 0xFFFF.
- R6: When the stored word differs from n, compare-and-exchange performs no write and replies 0x0000.
- R7: Mask command (+m, -v) with bit 0 of v clear replaces the enable mask with m.
- R8: Mask command (+m, -v) with bit 0 of v set raises stim_pulse[i] for exactly one cycle, in the cycle after the edge that takes v, for every i with m[i] and mask[i] both set.
- R9: Each access holds its strobe (output enable for reads, write enable for writes) low for WAIT_CYC+1 cycles. Write enable rises one cycle before the address may change. Write and output enable are never low together.
- R10: Reply back-pressure: once rsp_valid[c] is high it stays high with rsp_data unchanged until rsp_ready[c] is seen high at a clock edge.
- R11: Grants go round-robin, starting with the client after the last one served. Client 0 comes first after reset. At most one client sees cli_ready at a time, and a granted command, including its reply, finishes before any other client is granted.
- R12: A read reply becomes valid WAIT_CYC+3 rising edges after the edge that takes the offset word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cli_valid | input | 3 | Per-client command word valid |
| cli_ready | output | 3 | Per-client command word ready |
| cli_word | input | 54 | Client c command word at bits [c*18 +: 18] |
| rsp_valid | output | 3 | Per-client reply valid |
| rsp_ready | input | 3 | Per-client reply ready |
| rsp_data | output | 16 | Reply word for the client whose rsp_valid is high |
| sram_addr | output | 20 | SRAM address {page, offset} |
| sram_wdata | output | 16 | SRAM write data |
| sram_rdata | input | 16 | SRAM read data |
| sram_drive | output | 1 | High while the block drives write data onto the bus |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| stim_pulse | output | 16 | One-cycle stimulus pulse per master |

## Verification
The stimulus pulse is due in the cycle right after the edge that takes the second mask word. The bench samples stim_pulse 1 ns after that edge and then confirms it has cleared. A read reply is due WAIT_CYC+3 edges after the offset word is taken. The bench counts falling edges from that handshake and expects rsp_valid on exactly the WAIT_CYC+4th, which is the first falling edge after the reply edge. Strobe widths are counted at falling edges, and write results and the absence of replies are checked only after the write has had its full WAIT_CYC+2 access cycles to retire.

// File: rtl/xms_pkg.sv
package xms_pkg;

  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_WR  = 2'd1,
    OP_CAS = 2'd2,
    OP_MSK = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    T_IDLE  = 2'd0,
    T_TAKE  = 2'd1,
    T_MEM   = 2'd2,
    T_REPLY = 2'd3
  } tstate_e;

  typedef enum logic [1:0] {
    Q_IDLE = 2'd0,
    Q_ACC  = 2'd1,
    Q_REC  = 2'd2
  } qstate_e;

  // operation from the sign flags of word 0 and word 1
  function automatic op_e op_decode(input logic neg0, input logic neg1);
    case ({neg0, neg1})
      2'b00:   return OP_RD;
      2'b11:   return OP_WR;
      2'b10:   return OP_CAS;
      default: return OP_MSK;
    endcase
  endfunction

endpackage

// File: rtl/xms_rr.sv
module xms_rr #(
  parameter int N = 3,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          take,
  output logic          any,
  output logic [IW-1:0] pick
);

  logic [IW-1:0] last_q;

  always_comb begin
    any  = 1'b0;
    pick = last_q;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = int'(last_q) + k;
      if (idx >= N) idx = idx - N;
      if (!any && req[idx]) begin
        any  = 1'b1;
        pick = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    last_q <= IW'(N - 1);
    else if (take) last_q <= pick;
  end

endmodule

// File: rtl/xms_sram_seq.sv
module xms_sram_seq
  import xms_pkg::*;
#(
  parameter int AW   = 20,
  parameter int DW   = 16,
  parameter int WAIT = 2,
  localparam int CW  = $clog2(WAIT + 1) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          go_wr,
  input  logic [AW-1:0] go_addr,
  input  logic [DW-1:0] go_data,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] sram_addr,
  output logic [DW-1:0] sram_wdata,
  input  logic [DW-1:0] sram_rdata,
  output logic          sram_drive,
  output logic          sram_ce_n,
  output logic          sram_we_n,
  output logic          sram_oe_n
);

  qstate_e       st_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= Q_IDLE;
      cnt_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      wr_q   <= 1'b0;
      done   <= 1'b0;
      rdata  <= '0;
    end else begin
      done <= 1'b0;
      case (st_q)
        Q_IDLE: begin
          if (go) begin
            addr_q <= go_addr;
            data_q <= go_data;
            wr_q   <= go_wr;
            cnt_q  <= '0;
            st_q   <= Q_ACC;
          end
        end
        Q_ACC: begin
          if (cnt_q == CW'(WAIT)) begin
            if (wr_q) begin
              st_q <= Q_REC;
            end else begin
              rdata <= sram_rdata;
              done  <= 1'b1;
              st_q  <= Q_IDLE;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        Q_REC: begin
          done <= 1'b1;
          st_q <= Q_IDLE;
        end
        default: st_q <= Q_IDLE;
      endcase
    end
  end

  assign sram_addr  = addr_q;
  assign sram_wdata = data_q;
  assign sram_drive = (st_q != Q_IDLE) && wr_q;
  assign sram_ce_n  = (st_q == Q_IDLE);
  assign sram_oe_n  = !((st_q == Q_ACC) && !wr_q);
  assign sram_we_n  = !((st_q == Q_ACC) && wr_q);

endmodule

// File: rtl/xms_stim.sv
module xms_stim #(
  parameter int MW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic          post_en,
  input  logic [MW-1:0] val,
  output logic [MW-1:0] mask_q,
  output logic [MW-1:0] pulse_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '0;
      pulse_q <= '0;
    end else begin
      pulse_q <= post_en ? (val & mask_q) : '0;
      if (set_en) mask_q <= val;
    end
  end

endmodule

// File: rtl/xms_top.sv
module xms_top
  import xms_pkg::*;
#(
  parameter int NCLI     = 3,
  parameter int WAIT_CYC = 2,
  parameter int PAGE_W   = 4,
  parameter int DATA_W   = 16,
  localparam int WORD_W  = DATA_W + 2,
  localparam int SIGN_B  = WORD_W - 1,
  localparam int AW      = PAGE_W + DATA_W,
  localparam int IW      = (NCLI > 1) ? $clog2(NCLI) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCLI-1:0]        cli_valid,
  output logic [NCLI-1:0]        cli_ready,
  input  logic [NCLI*WORD_W-1:0] cli_word,
  output logic [NCLI-1:0]        rsp_valid,
  input  logic [NCLI-1:0]        rsp_ready,
  output logic [DATA_W-1:0]      rsp_data,
  output logic [AW-1:0]          sram_addr,
  output logic [DATA_W-1:0]      sram_wdata,
  input  logic [DATA_W-1:0]      sram_rdata,
  output logic                   sram_drive,
  output logic                   sram_ce_n,
  output logic                   sram_we_n,
  output logic                   sram_oe_n,
  output logic [DATA_W-1:0]      stim_pulse
);

  tstate_e          st_q;
  logic [IW-1:0]    owner_q;
  logic [1:0]       cnt_q;
  logic             s0_q, cas_ph_q;
  op_e              op_q;
  logic [DATA_W-1:0] w0_q, w1_q, w2_q, wnew_q, rsp_q;
  logic             go_q, go_wr_q;
  logic [AW-1:0]    go_addr_q;
  logic [DATA_W-1:0] go_data_q;

  logic             arb_any, arb_take;
  logic [IW-1:0]    arb_pick;
  logic             seq_done;
  logic [DATA_W-1:0] seq_rdata;
  logic [DATA_W-1:0] en_mask;

  // current word of the granted client
  logic [WORD_W-1:0] cur_word;
  logic [DATA_W-1:0] cur_val;
  logic              cur_neg, hs;
  logic              pad_unused;
  op_e               kind_now;
  logic              msk_fire;

  assign cur_word   = cli_word[owner_q*WORD_W +: WORD_W];
  assign cur_val    = cur_word[DATA_W-1:0];
  assign cur_neg    = cur_word[SIGN_B];
  assign pad_unused = ^cur_word[SIGN_B-1:DATA_W];
  assign hs         = (st_q == T_TAKE) && cli_valid[owner_q];
  assign kind_now   = (cnt_q == 2'd1) ? op_decode(s0_q, cur_neg) : op_q;
  assign msk_fire   = hs && (cnt_q == 2'd1) && (kind_now == OP_MSK);
  assign arb_take   = (st_q == T_IDLE) && arb_any;

  genvar gi;
  generate
    for (gi = 0; gi < NCLI; gi++) begin : g_cli
      assign cli_ready[gi] = (st_q == T_TAKE)  && (owner_q == IW'(gi));
      assign rsp_valid[gi] = (st_q == T_REPLY) && (owner_q == IW'(gi));
    end
  endgenerate

  assign rsp_data = rsp_q;

  xms_rr #(.N(NCLI)) u_rr (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (cli_valid),
    .take (arb_take),
    .any  (arb_any),
    .pick (arb_pick)
  );

  xms_sram_seq #(.AW(AW), .DW(DATA_W), .WAIT(WAIT_CYC)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go_q),
    .go_wr     (go_wr_q),
    .go_addr   (go_addr_q),
    .go_data   (go_data_q),
    .done      (seq_done),
    .rdata     (seq_rdata),
    .sram_addr (sram_addr),
    .sram_wdata(sram_wdata),
    .sram_rdata(sram_rdata),
    .sram_drive(sram_drive),
    .sram_ce_n (sram_ce_n),
    .sram_we_n (sram_we_n),
    .sram_oe_n (sram_oe_n)
  );

  xms_stim #(.MW(DATA_W)) u_stim (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (msk_fire && !cur_val[0]),
    .post_en(msk_fire && cur_val[0]),
    .val    (w0_q),
    .mask_q (en_mask),
    .pulse_q(stim_pulse)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= T_IDLE;
      owner_q   <= '0;
      cnt_q     <= '0;
      s0_q      <= 1'b0;
      cas_ph_q  <= 1'b0;
      op_q      <= OP_RD;
      w0_q      <= '0;
      w1_q      <= '0;
      w2_q      <= '0;
      wnew_q    <= '0;
      rsp_q     <= '0;
      go_q      <= 1'b0;
      go_wr_q   <= 1'b0;
      go_addr_q <= '0;
      go_data_q <= '0;
    end else begin
      go_q <= 1'b0;
      case (st_q)
        T_IDLE: begin
          cnt_q    <= '0;
          cas_ph_q <= 1'b0;
          if (arb_any) begin
            owner_q <= arb_pick;
            st_q    <= T_TAKE;
          end
        end
        T_TAKE: begin
          if (hs) begin
            case (cnt_q)
              2'd0: begin
                w0_q  <= cur_val;
                s0_q  <= cur_neg;
                cnt_q <= 2'd1;
              end
              2'd1: begin
                op_q <= kind_now;
                w1_q <= cur_val;
                if (kind_now == OP_RD) begin
                  go_q      <= 1'b1;
                  go_wr_q   <= 1'b0;
                  go_addr_q <= {w0_q[PAGE_W-1:0], cur_val};
                  st_q      <= T_MEM;
                end else if (kind_now == OP_MSK) begin
                  st_q <= T_IDLE;
                end else begin
                  cnt_q <= 2'd2;
                end
              end
              2'd2: begin
                w2_q <= cur_val;
                if (op_q == OP_WR) begin
                  go_q      <= 1'b1;
                  go_wr_q   <= 1'b1;
                  go_addr_q <= {w0_q[PAGE_W-1:0], w1_q};
                  go_data_q <= cur_val;
                  st_q      <= T_MEM;
                end else begin
                  cnt_q <= 2'd3;
                end
              end
              default: begin
                wnew_q    <= cur_val;
                go_q      <= 1'b1;
                go_wr_q   <= 1'b0;
                go_addr_q <= {w1_q[PAGE_W-1:0], w2_q};
                st_q      <= T_MEM;
              end
            endcase
          end
        end
        T_MEM: begin
          if (seq_done) begin
            case (op_q)
              OP_RD: begin
                rsp_q <= seq_rdata;
                st_q  <= T_REPLY;
              end
              OP_CAS: begin
                if (cas_ph_q) begin
                  rsp_q <= '1;
                  st_q  <= T_REPLY;
                end else if (seq_rdata == w0_q) begin
                  go_q      <= 1'b1;
                  go_wr_q   <= 1'b1;
                  go_data_q <= wnew_q;
                  cas_ph_q  <= 1'b1;
                end else begin
                  rsp_q <= '0;
                  st_q  <= T_REPLY;
                end
              end
              default: st_q <= T_IDLE;
            endcase
          end
        end
        T_REPLY: begin
          if (rsp_ready[owner_q]) st_q <= T_IDLE;
        end
        default: st_q <= T_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/xms_chk.sv
module xms_chk #(
  parameter int NCLI     = 3,
  parameter int WAIT_CYC = 2,
  parameter int DATA_W   = 16,
  parameter int AW       = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCLI-1:0]   cli_ready,
  input logic [NCLI-1:0]   rsp_valid,
  input logic [NCLI-1:0]   rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic [AW-1:0]     sram_addr,
  input logic              sram_ce_n,
  input logic              sram_we_n,
  input logic              sram_oe_n,
  input logic [DATA_W-1:0] stim_pulse,
  input logic [DATA_W-1:0] en_mask
);

  localparam int RW = $clog2(WAIT_CYC + 3) + 1;
  logic [RW-1:0] we_run_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                        we_run_q <= '0;
    else if (sram_we_n)                we_run_q <= '0;
    else if (we_run_q <= RW'(WAIT_CYC + 1)) we_run_q <= we_run_q + 1'b1;
  end

  // R11
  one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cli_ready) && $onehot0(rsp_valid));

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rsp_valid & ~rsp_ready) != '0) |=> (rsp_valid == $past(rsp_valid)) && $stable(rsp_data));

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sram_we_n && !sram_oe_n));

  // R9
  we_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |=> $stable(sram_addr));

  // R9
  we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_run_q <= RW'(WAIT_CYC + 1));

  // R3
  oe_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_oe_n || !sram_we_n) |-> !sram_ce_n);

  // R8
  stim_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stim_pulse & ~en_mask) == '0);

  // R8
  stim_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stim_pulse != '0) |=> (stim_pulse == '0));

endmodule

bind xms_top xms_chk #(
  .NCLI(NCLI), .WAIT_CYC(WAIT_CYC), .DATA_W(DATA_W), .AW(AW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cli_ready (cli_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .sram_addr (sram_addr),
  .sram_ce_n (sram_ce_n),
  .sram_we_n (sram_we_n),
  .sram_oe_n (sram_oe_n),
  .stim_pulse(stim_pulse),
  .en_mask   (en_mask)
);

// File: tb/xms_top_test.sv
`timescale 1ns/1ps
module xms_top_test;
  localparam int NCLI = 3;
  localparam int WAITC = 2;
  localparam int NV = 11;

  logic clk = 1'b0;
  logic rst_n;
  logic [NCLI-1:0] cli_valid, cli_ready, rsp_valid, rsp_ready;
  logic [NCLI*18-1:0] cli_word;
  logic [15:0] rsp_data, sram_wdata, sram_rdata, stim_pulse;
  logic [19:0] sram_addr;
  logic sram_drive, sram_ce_n, sram_we_n, sram_oe_n;

  always #10 clk = ~clk;

  xms_top #(.NCLI(NCLI), .WAIT_CYC(WAITC)) uut (
    .clk(clk), .rst_n(rst_n),
    .cli_valid(cli_valid), .cli_ready(cli_ready), .cli_word(cli_word),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_rdata(sram_rdata),
    .sram_drive(sram_drive), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n), .stim_pulse(stim_pulse)
  );

  // SRAM model, index {page, offset[7:0]}
  logic [15:0] mem [4096];
  int wr_count = 0;
  assign sram_rdata = (!sram_ce_n && !sram_oe_n) ? mem[{sram_addr[19:16], sram_addr[7:0]}] : 16'hDEAD;
  always @(posedge sram_we_n) begin
    if (sram_ce_n === 1'b0 && sram_drive === 1'b1) begin
      mem[{sram_addr[19:16], sram_addr[7:0]}] <= sram_wdata;
      wr_count++;
    end
  end

  int pcnt [16];
  int oe_lo = 0, we_lo = 0;
  always @(negedge clk) begin
    for (int i = 0; i < 16; i++) if (stim_pulse[i] === 1'b1) pcnt[i]++;
    if (sram_oe_n === 1'b0) oe_lo++;
    if (sram_we_n === 1'b0) we_lo++;
  end

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [17:0] mk(input logic neg, input logic [15:0] v);
    return {neg, 1'b0, v};
  endfunction

  task automatic send(input int c, input logic [17:0] w);
    @(negedge clk);
    cli_valid[c] = 1'b1;
    cli_word[c*18 +: 18] = w;
    while (!cli_ready[c]) @(negedge clk);
    @(posedge clk);
    #1 cli_valid[c] = 1'b0;
  endtask

  task automatic get_reply(input int c, input int hold, output logic [15:0] d);
    logic [15:0] first;
    while (!rsp_valid[c]) @(negedge clk);
    first = rsp_data;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(rsp_valid[c] && rsp_data == first, "R10 reply held", {16'h0, rsp_data}, {16'h0, first});
    end
    d = rsp_data;
    @(negedge clk);
    rsp_ready[c] = 1'b1;
    @(posedge clk);
    #1 rsp_ready[c] = 1'b0;
  endtask

  // {op[1:0] (0 rd,1 wr,2 cas), page[3:0], offset[15:0], data/new[15:0], cmp[15:0], expect[15:0]}
  localparam logic [85:0] VEC [NV] = '{
    {2'd1, 4'h5, 16'h0010, 16'h1234, 16'h0000, 16'h0000},
    {2'd0, 4'h5, 16'h0010, 16'h0000, 16'h0000, 16'h1234},
    {2'd1, 4'h0, 16'h0010, 16'h5555, 16'h0000, 16'h0000},
    {2'd0, 4'h5, 16'h0010, 16'h0000, 16'h0000, 16'h1234},
    {2'd0, 4'h0, 16'h0010, 16'h0000, 16'h0000, 16'h5555},
    {2'd2, 4'h5, 16'h0010, 16'hBEEF, 16'h1234, 16'hFFFF},
    {2'd0, 4'h5, 16'h0010, 16'h0000, 16'h0000, 16'hBEEF},
    {2'd2, 4'h5, 16'h0010, 16'h0000, 16'h1234, 16'h0000},
    {2'd0, 4'h5, 16'h0010, 16'h0000, 16'h0000, 16'hBEEF},
    {2'd1, 4'hF, 16'hFFFF, 16'hA5A5, 16'h0000, 16'h0000},
    {2'd0, 4'hF, 16'hFFFF, 16'h0000, 16'h0000, 16'hA5A5}
  };

  logic [15:0] d0, d1, d2, dd;
  int ord [NCLI];
  int ordn;

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
    for (int i = 0; i < 16; i++) pcnt[i] = 0;
    rst_n = 1'b0; cli_valid = '0; cli_word = '0; rsp_ready = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(sram_ce_n && sram_we_n && sram_oe_n, "R1 strobes in reset", {29'h0, sram_ce_n, sram_we_n, sram_oe_n}, 32'h7);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sram_ce_n && sram_we_n && sram_oe_n, "R1 strobes after reset", {29'h0, sram_ce_n, sram_we_n, sram_oe_n}, 32'h7);
    chk(cli_ready == 0 && rsp_valid == 0, "R1 handshakes idle", {26'h0, cli_ready, rsp_valid}, 32'h0);
    chk(stim_pulse == 0, "R1 no stimulus", {16'h0, stim_pulse}, 32'h0);

    // vector walk, client 0
    for (int i = 0; i < NV; i++) begin
      logic [1:0] op; logic [3:0] pg; logic [15:0] ofs, dat, cmpv, expv;
      int k, wc0;
      {op, pg, ofs, dat, cmpv, expv} = VEC[i];
      if (op == 2'd0) begin
        oe_lo = 0;
        send(0, mk(1'b0, {12'h0, pg}));
        send(0, mk(1'b0, ofs));
        k = 0;
        do begin @(negedge clk); k++; end while (!rsp_valid[0] && k < 50);
        chk(k == WAITC + 4, "R12 read reply latency", k, WAITC + 4);
        chk(oe_lo == WAITC + 1, "R9 R3 output enable width", oe_lo, WAITC + 1);
        get_reply(0, 0, dd);
        chk(dd == expv, "R3 R11 read data", {16'h0, dd}, {16'h0, expv});
      end else if (op == 2'd1) begin
        we_lo = 0; wc0 = wr_count;
        send(0, mk(1'b1, {12'h0, pg}));
        send(0, mk(1'b1, ofs));
        send(0, mk(1'b0, dat));
        repeat (WAITC + 6) @(negedge clk);
        chk(rsp_valid == 0, "R4 write gives no reply", {29'h0, rsp_valid}, 32'h0);
        chk(mem[{pg, ofs[7:0]}] == dat, "R4 write stored", {16'h0, mem[{pg, ofs[7:0]}]}, {16'h0, dat});
        chk(wr_count == wc0 + 1 && we_lo == WAITC + 1, "R9 write enable width", we_lo, WAITC + 1);
      end else begin
        wc0 = wr_count;
        send(0, mk(1'b1, cmpv));
        send(0, mk(1'b0, {12'h0, pg}));
        send(0, mk(1'b0, ofs));
        send(0, mk(1'b0, dat));
        get_reply(0, 0, dd);
        chk(dd == expv, "R5 R6 swap reply", {16'h0, dd}, {16'h0, expv});
        chk(wr_count == wc0 + ((expv == 16'hFFFF) ? 1 : 0), "R5 R6 swap write count", wr_count - wc0, (expv == 16'hFFFF) ? 1 : 0);
      end
    end

    // reply back-pressure
    send(0, mk(1'b0, 16'h0000));
    send(0, mk(1'b0, 16'h0010));
    get_reply(0, 5, dd);
    chk(dd == 16'h5555, "R10 data after stall", {16'h0, dd}, 32'h5555);

    // mask commands, client 1
    for (int i = 0; i < 16; i++) pcnt[i] = 0;
    send(1, mk(1'b0, 16'h00FF));
    send(1, mk(1'b1, 16'h0001));
    repeat (3) @(negedge clk);
    chk(pcnt.sum() == 0, "R1 R7 reset mask blocks posts", pcnt.sum(), 0);
    send(1, mk(1'b0, 16'h0005));
    send(1, mk(1'b1, 16'h0000));
    repeat (3) @(negedge clk);
    chk(pcnt.sum() == 0, "R7 mask load posts nothing", pcnt.sum(), 0);
    send(1, mk(1'b0, 16'h0007));
    send(1, mk(1'b1, 16'h0001));
    chk(stim_pulse == 16'h0005, "R8 pulse timing", {16'h0, stim_pulse}, 32'h5);
    @(posedge clk); #1;
    chk(stim_pulse == 16'h0000, "R8 pulse one cycle", {16'h0, stim_pulse}, 32'h0);
    repeat (2) @(negedge clk);
    chk(pcnt[0] == 1 && pcnt[2] == 1 && pcnt.sum() == 2, "R8 selected and enabled", pcnt.sum(), 2);
    send(1, mk(1'b0, 16'h0002));
    send(1, mk(1'b1, 16'h0000));
    send(1, mk(1'b0, 16'hFFFF));
    send(1, mk(1'b1, 16'h0001));
    repeat (3) @(negedge clk);
    chk(pcnt[1] == 1 && pcnt.sum() == 3, "R7 mask replaced", pcnt.sum(), 3);

    // round robin: last served client 1, so order 2,0,1
    ordn = 0;
    fork
      begin
        send(0, mk(1'b0, 16'h0000)); ord[0] = ordn; ordn++;
        send(0, mk(1'b0, 16'h0010)); get_reply(0, 0, d0);
      end
      begin
        send(1, mk(1'b0, 16'h0005)); ord[1] = ordn; ordn++;
        send(1, mk(1'b0, 16'h0010)); get_reply(1, 0, d1);
      end
      begin
        send(2, mk(1'b0, 16'h000F)); ord[2] = ordn; ordn++;
        send(2, mk(1'b0, 16'hFFFF)); get_reply(2, 0, d2);
      end
    join
    chk(ord[2] == 0 && ord[0] == 1 && ord[1] == 2, "R11 grant order", {ord[2][7:0], ord[0][7:0], ord[1][7:0]}, 32'h000102);
    chk(d0 == 16'h5555, "R11 client0 data", {16'h0, d0}, 32'h5555);
    chk(d1 == 16'hBEEF, "R11 client1 data", {16'h0, d1}, 32'hBEEF);
    chk(d2 == 16'hA5A5, "R2 client2 data", {16'h0, d2}, 32'hA5A5);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule